// File: doc/BRIEF.md
# Clock-Synthesiser Configuration Target on SMBus

This block is the serial configuration front end of a clock-synthesiser controller. It sits on a two-wire SMBus segment as a target only. A host uses it to program a small bank of 8-bit control registers. Its outputs are the decoded control fields: the spread enable for the differential clocks, two frequency-margining codes, and one enable per clock output. The analogue side of the chip reads these fields directly.

Every transfer is a block access. The host sends a starting register index and then either a byte count followed by that many data bytes (write), or a repeated start and the read address (read). On a read the target first returns how many bytes remain from the index to the top of the bank, then the register contents in order. An internal pointer advances after every byte. SCL and SDA come in as open-drain bus levels. They are oversampled in the system clock, synchronised and de-glitched. The target drives SDA only through a pull-down enable.

The active-low power-down pin also serves as the block's reset. While it is low, the bank holds its reset values and every clock output is disabled. When it is high, one register bit chooses the source of the global enable: the pin, or a software enable bit. That global enable is combined with each per-output enable.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The target acknowledges only address byte 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69. A read address is acknowledged only if a valid index was accepted earlier in the same transaction. Any other address byte is not acknowledged, and the target leaves SDA released for the rest of that transaction.
- R2: A block write is start, 0xD2, index, count N, then N data bytes. Each of these bytes is acknowledged, and the data bytes go to registers index, index+1, and so on. A data byte beyond N, or one aimed past register 6, is not acknowledged and is not written.
- R3: A write count of 0 is not acknowledged. No register changes in that transaction.
- R4: A block read is start, 0xD2, index, repeated start, 0xD3. The target then sends a count byte equal to 7 minus the index, followed by the registers from the index upward. It keeps sending while the host acknowledges and stops after a host NACK.
- R5: An index byte above 6 is not acknowledged, in both writes and reads.
- R6: After reset, registers 0 to 6 read 0x35, 0xF0, 0x80, 0x06, 0x00, 0x03, 0x00.
- R7: The following bits keep their reset value whatever is written to them: register 2 bits 4:0, register 3 bit 0, and all of registers 4, 5 and 6.
- R8: While the power-down pin is low, all output enables are 0. When the pin goes high again, every register holds its reset value.
- R9: Register 0 bit 6 selects the global enable source. When bit 6 is 0, the global enable follows the pin. When bit 6 is 1, bit 5 sets the global enable: 0 forces every enable low and 1 lets the per-output bits through.
- R10: Each output enable is its own bit ANDed with the global enable. The second 50 MHz output uses register 0 bit 0. The 32.256 MHz output, the first 50 MHz output and the selectable output use register 1 bits 7, 6 and 5. Differential outputs 4, 3, 2, 1 and 0 use register 3 bits 7, 5, 4, 2 and 1. The spread enable is register 0 bit 7, the 50 MHz margin code is register 0 bits 4:1, and the selectable-output code is register 2 bits 7:5.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored. A stop condition returns the target to idle, and in idle it acknowledges no byte until the next start.
- R12: The target changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| pwrdn_rst_n | input | 1 | Active-low power-down pin; asynchronous reset of the block |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |
| sda_pull | output | 1 | 1 = pull SDA low |
| spread_en | output | 1 | Spread enable for the differential clocks |
| fs50_sel | output | 4 | 50 MHz margining code |
| fsx_sel | output | 3 | Selectable-output frequency/margin code |
| oe_diff | output | 5 | Enables of differential outputs 4..0 |
| oe_50m_a | output | 1 | Enable of the first 50 MHz output |
| oe_50m_b | output | 1 | Enable of the second 50 MHz output |
| oe_32m | output | 1 | Enable of the 32.256 MHz output |
| oe_xsel | output | 1 | Enable of the selectable 33/66/133 MHz output |

## Verification
The bench targets the edges of the block protocol, where a design with a wrong count check or a wrong pointer would otherwise go unnoticed:
- A zero count must be refused. A design that accepted it would let the next byte land in a register.
- A write must stop at register 6 and at the count. A design that wrapped or ignored the count would acknowledge the overrun byte.
- An out-of-range index must be refused.
- The read count byte must match the index. An off-by-one in the pointer would show here.
- Read-only bits must hold their reset value. Masking that leaked would change a reserved or ID bit.

It also sends bytes with short SCL and SDA glitches. An unfiltered design would count extra bits or see a false stop. It sends a byte after a stop with no new start, which a target that never returns to idle would acknowledge. It pulses the power-down pin to confirm that the enables drop and the registers come back at their reset values.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_WCNT,
    ST_WDAT,
    ST_RTX,
    ST_IGNORE
  } smb_state_e;

  // value each register takes on reset
  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      0:       reg_reset = 8'h35;
      1:       reg_reset = 8'hF0;
      2:       reg_reset = 8'h80;
      3:       reg_reset = 8'h06;
      5:       reg_reset = 8'h03;
      default: reg_reset = 8'h00;
    endcase
  endfunction

  // 1 = bit accepts host writes
  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      0:       reg_wmask = 8'hFF;
      1:       reg_wmask = 8'hFF;
      2:       reg_wmask = 8'hE0;
      3:       reg_wmask = 8'hFE;
      default: reg_wmask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_deglitch.sv
module smb_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (synced != dout) begin
        if (run_q == CW'(FILT_LEN - 1)) begin
          dout  <= synced;
          run_q <= '0;
        end else begin
          run_q <= run_q + CW'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end

endmodule

// File: rtl/smb_block_engine.sv
module smb_block_engine
  import cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 7,
  localparam int        PW       = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  output logic          sda_pull,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] rd_idx,
  input  logic [7:0]    rd_data
);
  smb_state_e st, pend_st, dec_st;
  logic        scl_q, sda_q;
  logic        rise, fall, start_ev, stop_ev;
  logic [3:0]  cnt;
  logic [7:0]  rx_sh, tx_sh, wr_left;
  logic        tx_on, ack_drv, m_ack, ptr_ok;
  logic [PW-1:0] ptr;
  logic        ptr_in, dec_ack, dec_wr;
  logic [7:0]  rem_cnt;

  assign rise     = scl_f & ~scl_q;
  assign fall     = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign ptr_in   = (ptr < PW'(NREG));
  assign rem_cnt  = 8'(NREG) - 8'(ptr);
  assign rd_idx   = ptr;
  assign sda_pull = ack_drv | (tx_on & ~tx_sh[7]);

  // decision taken when eight bits of a received byte are in
  always_comb begin
    dec_ack = 1'b0;
    dec_wr  = 1'b0;
    dec_st  = ST_IGNORE;
    case (st)
      ST_ADDR: if (rx_sh[7:1] == DEV_ADDR) begin
        if (!rx_sh[0]) begin
          dec_ack = 1'b1;
          dec_st  = ST_OFFS;
        end else if (ptr_ok) begin
          dec_ack = 1'b1;
          dec_st  = ST_RTX;
        end
      end
      ST_OFFS: if (rx_sh < 8'(NREG)) begin
        dec_ack = 1'b1;
        dec_st  = ST_WCNT;
      end
      ST_WCNT: if (rx_sh != 8'd0) begin
        dec_ack = 1'b1;
        dec_st  = ST_WDAT;
      end
      ST_WDAT: if (wr_left != 8'd0 && ptr_in) begin
        dec_ack = 1'b1;
        dec_wr  = 1'b1;
        dec_st  = ST_WDAT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pend_st <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      cnt     <= 4'd0;
      rx_sh   <= 8'd0;
      tx_sh   <= 8'hFF;
      tx_on   <= 1'b0;
      ack_drv <= 1'b0;
      m_ack   <= 1'b0;
      ptr     <= '0;
      ptr_ok  <= 1'b0;
      wr_left <= 8'd0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= 8'd0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (stop_ev) begin
        st      <= ST_IDLE;
        cnt     <= 4'd0;
        ack_drv <= 1'b0;
        tx_on   <= 1'b0;
        ptr_ok  <= 1'b0;
      end else if (start_ev) begin
        st      <= ST_ADDR;
        cnt     <= 4'd0;
        ack_drv <= 1'b0;
        tx_on   <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) rx_sh <= {rx_sh[6:0], sda_f};
          if (cnt == 4'd8) m_ack <= ~sda_f;
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end
        if (fall) begin
          if (cnt != 4'd0 && cnt < 4'd8) begin
            if (tx_on) tx_sh <= {tx_sh[6:0], 1'b1};
          end else if (cnt == 4'd8) begin
            if (st == ST_RTX) begin
              tx_on <= 1'b0;
            end else begin
              ack_drv <= dec_ack;
              pend_st <= dec_st;
              if (dec_wr) begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= rx_sh;
                ptr     <= ptr + PW'(1);
                wr_left <= wr_left - 8'd1;
              end
              if (st == ST_OFFS && dec_ack) begin
                ptr    <= rx_sh[PW-1:0];
                ptr_ok <= 1'b1;
              end
              if (st == ST_WCNT && dec_ack) wr_left <= rx_sh;
            end
          end else if (cnt == 4'd9) begin
            cnt     <= 4'd0;
            ack_drv <= 1'b0;
            if (st == ST_RTX) begin
              if (m_ack) begin
                tx_sh <= ptr_in ? rd_data : 8'hFF;
                tx_on <= 1'b1;
                if (ptr_in) ptr <= ptr + PW'(1);
              end else begin
                st <= ST_IGNORE;
              end
            end else begin
              st <= pend_st;
              if (pend_st == ST_RTX) begin
                tx_sh <= rem_cnt;
                tx_on <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assert_sda_quiet_scl_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull));

  assert_no_drive_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_IGNORE) |-> !sda_pull);

  assert_write_is_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ack_drv);

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_pkg::*;
#(
  parameter int  NREG = 7,
  localparam int PW   = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          spread_en,
  output logic [3:0]    fs50_sel,
  output logic [2:0]    fsx_sel,
  output logic [4:0]    oe_diff,
  output logic          oe_50m_a,
  output logic          oe_50m_b,
  output logic          oe_32m,
  output logic          oe_xsel
);
  logic [7:0] regs [NREG];
  logic       sw_ctl, sw_en, glob_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_reset(i);
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (wr_idx == PW'(i))
          regs[i] <= (wr_data & reg_wmask(i)) | (regs[i] & ~reg_wmask(i));
    end
  end

  assign rd_data = (rd_idx < PW'(NREG)) ? regs[rd_idx] : 8'hFF;

  assign sw_ctl  = regs[0][6];
  assign sw_en   = regs[0][5];
  assign glob_en = sw_ctl ? sw_en : rst_n;

  assign spread_en = regs[0][7];
  assign fs50_sel  = regs[0][4:1];
  assign fsx_sel   = regs[2][7:5];
  assign oe_50m_b  = regs[0][0] & glob_en;
  assign oe_32m    = regs[1][7] & glob_en;
  assign oe_50m_a  = regs[1][6] & glob_en;
  assign oe_xsel   = regs[1][5] & glob_en;
  assign oe_diff   = {regs[3][7], regs[3][5], regs[3][4], regs[3][2], regs[3][1]} & {5{glob_en}};

  for (genvar g = 0; g < NREG; g++) begin : g_ro_chk
    assert_ro_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs[g] & ~reg_wmask(g)));
  end

  assert_sw_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[0][6] && !regs[0][5]) |-> (oe_diff == 5'd0 && !oe_50m_a && !oe_50m_b && !oe_32m && !oe_xsel));

endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
  import cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 7,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       pwrdn_rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic       spread_en,
  output logic [3:0] fs50_sel,
  output logic [2:0] fsx_sel,
  output logic [4:0] oe_diff,
  output logic       oe_50m_a,
  output logic       oe_50m_b,
  output logic       oe_32m,
  output logic       oe_xsel
);
  localparam int PW = $clog2(NREG + 1);

  logic [1:0]    raw_lines, filt_lines;
  logic          wr_en;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data;

  assign raw_lines = {sda_in, scl_in};

  for (genvar k = 0; k < 2; k++) begin : g_line
    smb_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_dg (
      .clk  (clk),
      .rst_n(pwrdn_rst_n),
      .din  (raw_lines[k]),
      .dout (filt_lines[k])
    );
  end

  smb_block_engine #(
    .DEV_ADDR(DEV_ADDR),
    .NREG    (NREG)
  ) u_engine (
    .clk     (clk),
    .rst_n   (pwrdn_rst_n),
    .scl_f   (filt_lines[0]),
    .sda_f   (filt_lines[1]),
    .sda_pull(sda_pull),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  cfg_regbank #(
    .NREG(NREG)
  ) u_regs (
    .clk      (clk),
    .rst_n    (pwrdn_rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .spread_en(spread_en),
    .fs50_sel (fs50_sel),
    .fsx_sel  (fsx_sel),
    .oe_diff  (oe_diff),
    .oe_50m_a (oe_50m_a),
    .oe_50m_b (oe_50m_b),
    .oe_32m   (oe_32m),
    .oe_xsel  (oe_xsel)
  );

endmodule

// File: tb/clkcfg_smbus_slave_bench.sv
module clkcfg_smbus_slave_bench;
  localparam int QTR = 16;

  logic clk = 1'b0;
  logic pwrdn_rst_n = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus;
  logic sda_pull, spread_en, oe_50m_a, oe_50m_b, oe_32m, oe_xsel;
  logic [3:0] fs50_sel;
  logic [2:0] fsx_sel;
  logic [4:0] oe_diff;
  logic [8:0] oe_all;

  int n_chk = 0, n_fail = 0, r12_bad = 0;
  bit mon_on = 1'b0;
  logic scl_d = 1'b1, pull_d = 1'b0;

  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  bit         ackv [12];

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [8] = '{
    {8'd0, 8'hA5, 8'hA5},
    {8'd1, 8'h3C, 8'h3C},
    {8'd2, 8'hFF, 8'hE0},
    {8'd3, 8'hFF, 8'hFE},
    {8'd4, 8'h55, 8'h00},
    {8'd5, 8'hAA, 8'h03},
    {8'd6, 8'h12, 8'h00},
    {8'd2, 8'h5F, 8'h40}
  };

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull;
  assign oe_all  = {oe_diff, oe_50m_a, oe_50m_b, oe_32m, oe_xsel};

  clkcfg_smbus_slave u_clkcfg_smbus_slave (
    .clk        (clk),
    .pwrdn_rst_n(pwrdn_rst_n),
    .scl_in     (m_scl),
    .sda_in     (sda_bus),
    .sda_pull   (sda_pull),
    .spread_en  (spread_en),
    .fs50_sel   (fs50_sel),
    .fsx_sel    (fsx_sel),
    .oe_diff    (oe_diff),
    .oe_50m_a   (oe_50m_a),
    .oe_50m_b   (oe_50m_b),
    .oe_32m     (oe_32m),
    .oe_xsel    (oe_xsel)
  );

  always @(negedge clk) begin
    if (mon_on && m_scl && scl_d && (sda_pull != pull_d)) r12_bad++;
    scl_d  = m_scl;
    pull_d = sda_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    m_sda = 1'b0; q();
    m_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q();
    m_scl = 1'b1; q();
    m_sda = 1'b1; q(); q();
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q();
      m_scl = 1'b1;
      if (glitch) begin
        repeat (QTR/2) @(negedge clk);
        m_scl = 1'b0; repeat (2) @(negedge clk);
        m_scl = 1'b1; repeat (QTR/2 - 2) @(negedge clk);
        repeat (QTR/2) @(negedge clk);
        m_sda = ~b[i]; repeat (2) @(negedge clk);
        m_sda = b[i]; repeat (QTR/2 - 2) @(negedge clk);
      end else begin
        q(); q();
      end
      m_scl = 1'b0; q();
    end
    m_sda = 1'b1; q();
    m_scl = 1'b1; q();
    ack = ~sda_bus; q();
    m_scl = 1'b0; q();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1'b1; q();
      b[i] = sda_bus; q();
      m_scl = 1'b0; q();
    end
    m_sda = give_ack ? 1'b0 : 1'b1; q();
    m_scl = 1'b1; q(); q();
    m_scl = 1'b0; q();
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] off, input logic [7:0] cnt,
                          input int nd, input bit glitch);
    bus_start();
    put_byte(addr, glitch, ackv[0]);
    put_byte(off, glitch, ackv[1]);
    put_byte(cnt, glitch, ackv[2]);
    for (int i = 0; i < nd; i++) put_byte(wbuf[i], glitch, ackv[3+i]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] off, input int nd);
    bus_start();
    put_byte(8'hD2, 1'b0, ackv[0]);
    put_byte(off, 1'b0, ackv[1]);
    bus_rstart();
    put_byte(8'hD3, 1'b0, ackv[2]);
    get_byte(1'b1, rbuf[0]);
    for (int i = 0; i < nd; i++) get_byte(i != nd - 1, rbuf[1+i]);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #5 pwrdn_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 enables low while pin low", 32'(oe_all), 32'h000);
    pwrdn_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;

    // R6 / R10 reset state at ports
    chk("R10 default enables", 32'(oe_all), 32'h03F);
    chk("R10 default fields", {23'd0, spread_en, fs50_sel, fsx_sel}, {23'd0, 1'b0, 4'b1010, 3'b100});

    // R6 reset readback, R4 count from index 0
    do_read(8'd0, 7);
    chk("R4 count byte from 0", 32'(rbuf[0]), 32'd7);
    chk("R6 reg0", 32'(rbuf[1]), 32'h35);
    chk("R6 reg1", 32'(rbuf[2]), 32'hF0);
    chk("R6 reg2", 32'(rbuf[3]), 32'h80);
    chk("R6 reg3", 32'(rbuf[4]), 32'h06);
    chk("R6 reg4", 32'(rbuf[5]), 32'h00);
    chk("R6 reg5", 32'(rbuf[6]), 32'h03);
    chk("R6 reg6", 32'(rbuf[7]), 32'h00);

    // table walk: single write then single read (R2, R4, R7)
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][15:8];
      do_write(8'hD2, VEC[v][23:16], 8'd1, 1, 1'b0);
      chk("R2 table write acked", {28'd0, ackv[0], ackv[1], ackv[2], ackv[3]}, 32'hF);
      do_read(VEC[v][23:16], 1);
      chk("R4 table count byte", 32'(rbuf[0]), 32'd7 - 32'(VEC[v][23:16]));
      chk("R7 table readback", 32'(rbuf[1]), 32'(VEC[v][7:0]));
    end

    // R2 multi-byte write with auto-increment, R4 multi-byte read
    wbuf[0] = 8'hE0; wbuf[1] = 8'h60; wbuf[2] = 8'hA4;
    do_write(8'hD2, 8'd1, 8'd3, 3, 1'b0);
    chk("R2 burst acks", {26'd0, ackv[0], ackv[1], ackv[2], ackv[3], ackv[4], ackv[5]}, 32'h3F);
    do_read(8'd1, 6);
    chk("R4 count from 1", 32'(rbuf[0]), 32'd6);
    chk("R4 burst data", {rbuf[1], rbuf[2], rbuf[3]}, 32'hE060A4);
    chk("R4 burst tail", {rbuf[4], rbuf[5], rbuf[6]}, 32'h000300);

    // R2 write runs past last register
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    do_write(8'hD2, 8'd5, 8'd3, 3, 1'b0);
    chk("R2 past last reg NACK", {29'd0, ackv[3], ackv[4], ackv[5]}, 32'b110);

    // R2 byte beyond count NACKed, R10 decode
    wbuf[0] = 8'h9A; wbuf[1] = 8'h77;
    do_write(8'hD2, 8'd0, 8'd1, 2, 1'b0);
    chk("R2 beyond count NACK", {30'd0, ackv[3], ackv[4]}, 32'b10);
    do_read(8'd0, 1);
    chk("R2 extra byte not written", 32'(rbuf[1]), 32'h9A);
    chk("R10 enable map", 32'(oe_all), 32'b110101011);
    chk("R10 field decode", {24'd0, spread_en, fs50_sel, fsx_sel}, {24'd0, 1'b1, 4'b1101, 3'b011});

    // R9 software control
    wbuf[0] = 8'h55;
    do_write(8'hD2, 8'd0, 8'd1, 1, 1'b0);
    chk("R9 software disable", 32'(oe_all), 32'h000);
    wbuf[0] = 8'h75;
    do_write(8'hD2, 8'd0, 8'd1, 1, 1'b0);
    chk("R9 software enable", 32'(oe_all), 32'b110101111);

    // R3 zero count
    wbuf[0] = 8'h00;
    do_write(8'hD2, 8'd1, 8'd0, 1, 1'b0);
    chk("R3 zero count NACK", {30'd0, ackv[2], ackv[3]}, 32'b00);
    do_read(8'd1, 1);
    chk("R3 register unchanged", 32'(rbuf[1]), 32'hE0);

    // R5 out-of-range index
    do_write(8'hD2, 8'd7, 8'd1, 0, 1'b0);
    chk("R5 write index 7 NACK", 32'(ackv[1]), 32'd0);
    do_read(8'd9, 0);
    chk("R5 read index 9 NACK", 32'(ackv[1]), 32'd0);

    // R1 address filtering
    do_write(8'hA4, 8'd1, 8'd1, 0, 1'b0);
    chk("R1 foreign address NACK", 32'(ackv[0]), 32'd0);
    do_write(8'hD4, 8'd1, 8'd1, 0, 1'b0);
    chk("R1 neighbour address NACK", 32'(ackv[0]), 32'd0);
    bus_start();
    put_byte(8'hD3, 1'b0, ackv[0]);
    bus_stop();
    chk("R1 read without index NACK", 32'(ackv[0]), 32'd0);

    // R11 glitch rejection
    wbuf[0] = 8'h5A;
    do_write(8'hD2, 8'd1, 8'd1, 1, 1'b1);
    chk("R11 glitched write acks", {28'd0, ackv[0], ackv[1], ackv[2], ackv[3]}, 32'hF);
    do_read(8'd1, 1);
    chk("R11 glitched write value", 32'(rbuf[1]), 32'h5A);

    // R11 stop returns to idle
    wbuf[0] = 8'h11;
    do_write(8'hD2, 8'd1, 8'd2, 1, 1'b0);
    put_byte(8'hD2, 1'b0, ackv[0]);
    put_byte(8'h22, 1'b0, ackv[1]);
    chk("R11 idle after stop NACK", {30'd0, ackv[0], ackv[1]}, 32'b00);
    bus_stop();
    do_read(8'd1, 2);
    chk("R11 aborted burst", {rbuf[1], rbuf[2]}, 32'h1160);

    // R8 power-down pulse
    @(negedge clk);
    pwrdn_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 enables drop on pin low", 32'(oe_all), 32'h000);
    pwrdn_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 enables after pin high", 32'(oe_all), 32'h03F);
    do_read(8'd0, 2);
    chk("R8 registers back to reset", {rbuf[1], rbuf[2]}, 32'h35F0);

    chk("R12 SDA changes only while SCL low", r12_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule